// File: doc/BRIEF.md
# Sixteen-Function Parameterized ALU

This block is a purely combinational arithmetic-logic unit. Two unsigned operands of a configurable width `N` (16 bits by default) enter on `opnd_a` and `opnd_b`. A 4-bit function code on `op_sel` chooses what appears on the single `N`-bit `result` output. There are sixteen functions: four arithmetic operations, single-position shifts and rotates of `opnd_a`, six two-input bitwise functions, and two magnitude/identity tests.

Internally the functions are split into three groups. An arithmetic group, a shift/rotate group and a bitwise/compare group each compute their answer. A final selector picks one answer using the upper code bits. The selector holds no state, so the result follows any input change without a clock.

Corner cases always give a defined output. Division by zero returns all ones. The compare functions return 0 or 1 in bit 0, and every upper bit is zero.

Top module: `opsel_alu`

## Requirements
- R1: Code 0000 outputs opnd_a + opnd_b modulo 2^N (the carry out is dropped).
- R2: Code 0001 outputs opnd_a - opnd_b modulo 2^N (an unsigned borrow wraps).
- R3: Code 0010 outputs the low N bits of the unsigned product opnd_a * opnd_b.
- R4: Code 0011 with a non-zero opnd_b outputs the unsigned quotient opnd_a / opnd_b, truncated toward zero.
- R5: Code 0011 with opnd_b equal to zero outputs all ones.
- R6: Code 0100 shifts opnd_a left by one position and puts 0 in bit 0. Code 0101 shifts opnd_a right by one position and puts 0 in bit N-1. opnd_b has no effect on either code.
- R7: Code 0110 rotates opnd_a left by one, so the old bit N-1 lands in bit 0. Code 0111 rotates opnd_a right by one, so the old bit 0 lands in bit N-1. opnd_b has no effect on either code.
- R8: Codes 1000, 1001, 1010, 1011, 1100 and 1101 output the bitwise AND, OR, XOR, NOR, NAND and XNOR of the operands, in that code order.
- R9: Code 1110 outputs 1 in bit 0 when opnd_a is greater than opnd_b as unsigned numbers, and 0 otherwise. Bits N-1..1 are zero.
- R10: Code 1111 outputs 1 in bit 0 when opnd_a equals opnd_b, and 0 otherwise. Bits N-1..1 are zero.
- R11: result is combinational: it reflects a change of opnd_a, opnd_b or op_sel with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | N | First unsigned operand; the only operand of shifts and rotates |
| opnd_b | input | N | Second unsigned operand |
| op_sel | input | 4 | Function code, 0000 to 1111 |
| result | output | N | Output of the selected function |

## Verification
The checker watches every input change for a set of properties. Division by zero must give all ones. The compare codes must leave the upper bits zero and give the correct equality bit. A rotate must keep the number of set bits. A left shift must zero-fill bit 0. The XNOR code must match the inverse of XOR. Exact arithmetic values need the bench's directed scenarios, which compare against an independent model. So do the carry and borrow wraps, the truncated product, truncating division, the behaviour of the shift right and rotate at the edge bits, the fact that opnd_b does not affect the single-operand codes, and a response with no clock edge.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_MUL  = 4'h2,
      OP_DIV  = 4'h3,
      OP_SHL  = 4'h4,
      OP_SHR  = 4'h5,
      OP_ROL  = 4'h6,
      OP_ROR  = 4'h7,
      OP_AND  = 4'h8,
      OP_OR   = 4'h9,
      OP_XOR  = 4'hA,
      OP_NOR  = 4'hB,
      OP_NAND = 4'hC,
      OP_XNOR = 4'hD,
      OP_GT   = 4'hE,
      OP_EQ   = 4'hF
   } alu_op_e;

   localparam int unsigned OP_W = 4;

endpackage

// File: rtl/alu_arith_grp.sv
module alu_arith_grp #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic [1:0]   fsel,
   output logic [N-1:0] y
);
   localparam logic [N-1:0] ALL_ONES = {N{1'b1}};
   localparam logic [N-1:0] ZERO     = {N{1'b0}};

   logic [N-1:0] sum_w;
   logic [N-1:0] diff_w;
   logic [N-1:0] prod_w;
   logic [N-1:0] quot_w;

   assign sum_w  = a + b;
   assign diff_w = a - b;
   assign prod_w = a * b;

   always_comb begin
      if (b == ZERO) quot_w = ALL_ONES;
      else           quot_w = a / b;
   end

   always_comb begin
      unique case (fsel)
         2'd0:    y = sum_w;
         2'd1:    y = diff_w;
         2'd2:    y = prod_w;
         default: y = quot_w;
      endcase
   end
endmodule

// File: rtl/alu_shift_grp.sv
module alu_shift_grp #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] a,
   input  logic [1:0]   fsel,
   output logic [N-1:0] y
);
   logic [N-1:0] shl_w;
   logic [N-1:0] shr_w;
   logic [N-1:0] rol_w;
   logic [N-1:0] ror_w;

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         assign shl_w[i] = 1'b0;
         assign rol_w[i] = a[N-1];
      end else begin : g_up
         assign shl_w[i] = a[i-1];
         assign rol_w[i] = a[i-1];
      end
      if (i == N-1) begin : g_msb
         assign shr_w[i] = 1'b0;
         assign ror_w[i] = a[0];
      end else begin : g_dn
         assign shr_w[i] = a[i+1];
         assign ror_w[i] = a[i+1];
      end
   end

   always_comb begin
      unique case (fsel)
         2'd0:    y = shl_w;
         2'd1:    y = shr_w;
         2'd2:    y = rol_w;
         default: y = ror_w;
      endcase
   end
endmodule

// File: rtl/alu_logic_grp.sv
module alu_logic_grp #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic [2:0]   fsel,
   output logic [N-1:0] y
);
   localparam logic [N-2:0] UPPER_ZERO = {(N-1){1'b0}};

   logic [N-1:0] and_w;
   logic [N-1:0] or_w;
   logic [N-1:0] xor_w;
   logic         gt_w;
   logic         eq_w;

   assign and_w = a & b;
   assign or_w  = a | b;
   assign xor_w = a ^ b;
   assign gt_w  = (a > b);
   assign eq_w  = (xor_w == {N{1'b0}});

   always_comb begin
      unique case (fsel)
         3'd0:    y = and_w;
         3'd1:    y = or_w;
         3'd2:    y = xor_w;
         3'd3:    y = ~or_w;
         3'd4:    y = ~and_w;
         3'd5:    y = ~xor_w;
         3'd6:    y = {UPPER_ZERO, gt_w};
         default: y = {UPPER_ZERO, eq_w};
      endcase
   end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu #(
   parameter int unsigned N = 16
) (
   input  logic [N-1:0] opnd_a,
   input  logic [N-1:0] opnd_b,
   input  logic [3:0]   op_sel,
   output logic [N-1:0] result
);
   import opsel_alu_pkg::*;

   if (N < 2) begin : g_bad_width
      $error("opsel_alu: N must be at least 2");
   end

   logic [N-1:0] arith_y;
   logic [N-1:0] shift_y;
   logic [N-1:0] logic_y;

   alu_arith_grp #(.N(N)) u_arith (
      .a    (opnd_a),
      .b    (opnd_b),
      .fsel (op_sel[1:0]),
      .y    (arith_y)
   );

   alu_shift_grp #(.N(N)) u_shift (
      .a    (opnd_a),
      .fsel (op_sel[1:0]),
      .y    (shift_y)
   );

   alu_logic_grp #(.N(N)) u_logic (
      .a    (opnd_a),
      .b    (opnd_b),
      .fsel (op_sel[2:0]),
      .y    (logic_y)
   );

   always_comb begin
      if (!op_sel[3]) result = op_sel[2] ? shift_y : arith_y;
      else            result = logic_y;
   end
endmodule

// File: rtl/opsel_alu_chk.sv
module opsel_alu_chk #(
   parameter int unsigned N = 16
) (
   input logic [N-1:0] opnd_a,
   input logic [N-1:0] opnd_b,
   input logic [3:0]   op_sel,
   input logic [N-1:0] result
);
   import opsel_alu_pkg::*;

   always_comb begin
      if (op_sel == OP_DIV && opnd_b == '0)
         assert_div_zero_R5: assert (result == {N{1'b1}})
            else $error("division by zero not all ones");
      if (op_sel == OP_GT || op_sel == OP_EQ)
         assert_cmp_upper_R9: assert (result[N-1:1] == '0)
            else $error("compare upper bits not zero");
      if (op_sel == OP_EQ)
         assert_eq_bit_R10: assert (result[0] == (opnd_a == opnd_b))
            else $error("equality bit wrong");
      if (op_sel == OP_ROL || op_sel == OP_ROR)
         assert_rot_keep_R7: assert ($countones(result) == $countones(opnd_a))
            else $error("rotate lost bits");
      if (op_sel == OP_SHL)
         assert_shl_fill_R6: assert (result[0] == 1'b0 && result[N-1:1] == opnd_a[N-2:0])
            else $error("shift left wrong");
      if (op_sel == OP_XNOR)
         assert_xnor_R8: assert ((result ^ opnd_a ^ opnd_b) == {N{1'b1}})
            else $error("xnor wrong");
   end
endmodule

bind opsel_alu opsel_alu_chk #(.N(N)) u_chk (
   .opnd_a (opnd_a),
   .opnd_b (opnd_b),
   .op_sel (op_sel),
   .result (result)
);

// File: tb/sim_opsel_alu.sv
`timescale 1ns/1ps
module sim_opsel_alu;
   localparam int unsigned N = 16;

   logic         clk = 1'b0;
   logic [N-1:0] a = '0;
   logic [N-1:0] b = '0;
   logic [3:0]   op = 4'h0;
   logic [N-1:0] res;
   int n_chk = 0;
   int n_bad = 0;
   logic done = 1'b0;

   always #5 clk = ~clk;

   opsel_alu #(.N(N)) u0 (.opnd_a(a), .opnd_b(b), .op_sel(op), .result(res));

   function automatic logic [N-1:0] model(input logic [3:0] f, input logic [N-1:0] x, input logic [N-1:0] y);
      logic [2*N-1:0] wide;
      case (f)
         4'h0: model = x + y;
         4'h1: model = x - y;
         4'h2: begin wide = {{N{1'b0}}, x} * {{N{1'b0}}, y}; model = wide[N-1:0]; end
         4'h3: model = (y == 0) ? {N{1'b1}} : x / y;
         4'h4: model = {x[N-2:0], 1'b0};
         4'h5: model = {1'b0, x[N-1:1]};
         4'h6: model = {x[N-2:0], x[N-1]};
         4'h7: model = {x[0], x[N-1:1]};
         4'h8: model = x & y;
         4'h9: model = x | y;
         4'hA: model = x ^ y;
         4'hB: model = ~(x | y);
         4'hC: model = ~(x & y);
         4'hD: model = ~(x ^ y);
         4'hE: model = (x > y) ? 1 : 0;
         default: model = (x == y) ? 1 : 0;
      endcase
   endfunction

   task automatic cmp(input string req, input logic [N-1:0] exp);
      n_chk++;
      if (res !== exp) begin
         n_bad++;
         $display("FAIL %s op=%h a=%h b=%h actual=%h expected=%h", req, op, a, b, res, exp);
      end
   endtask

   task automatic run(input string req, input logic [3:0] f, input logic [N-1:0] x, input logic [N-1:0] y);
      @(negedge clk);
      op = f; a = x; b = y;
      #1;
      cmp(req, model(f, x, y));
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      cmp("R1 initial", 16'h0000);
   endtask

   task automatic t_arith;
      run("R1", 4'h0, 16'h1234, 16'h0F0F);
      run("R1", 4'h0, 16'hFFFF, 16'h0002);
      run("R2", 4'h1, 16'h5000, 16'h1234);
      run("R2", 4'h1, 16'h0003, 16'h0005);
      run("R3", 4'h2, 16'h00FF, 16'h0101);
      run("R3", 4'h2, 16'h1234, 16'h5678);
   endtask

   task automatic t_div;
      run("R4", 4'h3, 16'd1000, 16'd7);
      run("R4", 4'h3, 16'd5, 16'd9);
      run("R4", 4'h3, 16'hFFFF, 16'h0001);
      run("R5", 4'h3, 16'h1234, 16'h0000);
      run("R5", 4'h3, 16'h0000, 16'h0000);
   endtask

   task automatic t_shift;
      run("R6", 4'h4, 16'h8001, 16'h0000);
      run("R6", 4'h4, 16'h8001, 16'hFFFF);
      run("R6", 4'h5, 16'h8001, 16'h1234);
      run("R6", 4'h5, 16'hFFFF, 16'hFFFF);
   endtask

   task automatic t_rotate;
      run("R7", 4'h6, 16'h8001, 16'h0000);
      run("R7", 4'h6, 16'h4000, 16'hFFFF);
      run("R7", 4'h7, 16'h8001, 16'hABCD);
      run("R7", 4'h7, 16'h0002, 16'h0000);
   endtask

   task automatic t_logic;
      for (int k = 8; k < 14; k++) begin
         run("R8", 4'(k), 16'hF0CC, 16'hAA0F);
         run("R8", 4'(k), 16'h0000, 16'hFFFF);
      end
   endtask

   task automatic t_compare;
      run("R9", 4'hE, 16'h8000, 16'h7FFF);
      run("R9", 4'hE, 16'h7FFF, 16'h8000);
      run("R9", 4'hE, 16'h1234, 16'h1234);
      run("R10", 4'hF, 16'hBEEF, 16'hBEEF);
      run("R10", 4'hF, 16'hBEEF, 16'hBEEE);
   endtask

   task automatic t_comb;
      @(posedge clk);
      #1;
      op = 4'h0; a = 16'h0010; b = 16'h0001;
      #1; cmp("R11", 16'h0011);
      b = 16'h0100;
      #1; cmp("R11", 16'h0110);
      op = 4'h8;
      #1; cmp("R11", 16'h0000);
   endtask

   initial begin
      t_reset();
      t_arith();
      t_div();
      t_shift();
      t_rotate();
      t_logic();
      t_compare();
      t_comb();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule